// File: doc/BRIEF.md
# Two-Bit Mealy Machine with Exclusive-OR State Update

This block is a small Mealy state machine with two state bits, one data input and one data output. It never computes the next state directly. A separate product-term function, the update mask, is combined with the present state by exclusive-OR. A bit of the mask is 1 exactly where the state bit must flip. The mask is an exclusive-OR sum of products of the data input and the present state bits.

A free-running system clock samples two control inputs on its rising edge. The update control `ctl_c` and the clear control `ctl_r` together choose one of three actions for the state register:

- load the updated state,
- keep the present state,
- force the constant state 00.

The output is formed from the data input and the low state bit, with no register in between.

Top module: `xdelta_mealy`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the state becomes 00 at that edge, whatever the control and data inputs are.
- R2: With `ctl_c`=0 and `ctl_r`=0 at a rising edge, the state takes its next value. Written as {x,state[1],state[0]} → next state, the mapping is: 000→10, 001→00, 010→01, 011→10, 100→11, 101→01, 110→01, 111→00.
- R3: With `ctl_c`=1 and `ctl_r`=0, the state keeps its present value at the edge.
- R4: With `ctl_c`=1 and `ctl_r`=1, the state becomes 00 at the edge.
- R5: With `ctl_c`=0 and `ctl_r`=1, the state keeps its present value; the clear takes effect only when `ctl_c` is also 1.
- R6: `z_out` is a combinational function of `x_in` and `state_q[0]`, equal to `state_q[0]` XOR NOT `x_in`, in every control mode. In table form, {x,state[1],state[0]}→z is: 000→1, 001→0, 010→1, 011→0, 100→0, 101→1, 110→0, 111→1.
- R7: `state_q` shows the present contents of the state register, with bit 1 as the high state bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes occur on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low; clears the state |
| ctl_c | input | 1 | Update control: 0 allows a load, 1 with `ctl_r`=0 keeps the state |
| ctl_r | input | 1 | Clear control: clears the state when `ctl_c` is also 1 |
| x_in | input | 1 | Data input of the machine |
| z_out | output | 1 | Mealy output, combinational from `x_in` and `state_q[0]` |
| state_q | output | 2 | Present state |

## Verification
The assertions check the control actions on every edge:

- the state stays put under either keep combination;
- it reaches 00 under a clear or a reset;
- a load equals the previous state XOR the previous update mask;
- `z_out` toggles whenever `x_in` toggles while the state is steady.

The assertions cannot show that the update mask yields the intended transition table. The bench's reference model shows this. It is built from the transition and output tables alone and is driven through random control and data sequences, a walk through every state/input pair, and a reset asserted on top of a load.

// File: rtl/xdelta_mealy_pkg.sv
// Package: shared widths, the state type, the register action codes and the
// reset value for the exclusive-OR update Mealy machine.
package xdelta_mealy_pkg;

    localparam int STATE_W = 2;
    localparam int MODE_W  = 2;

    typedef logic [STATE_W-1:0] state_t;

    typedef enum logic [MODE_W-1:0] {
        MODE_KEEP  = 2'd0,
        MODE_LOAD  = 2'd1,
        MODE_CLEAR = 2'd2
    } reg_mode_e;

    localparam state_t CLEAR_STATE = '0;

endpackage

// File: rtl/xdelta_mask.sv
// Update mask generator.
// Computes, from the data input and the present state, the mask of state
// bits that must flip on a load. Each mask bit is an exclusive-OR sum of
// product terms. Assumes the two-bit state encoding of the package.
module xdelta_mask
    import xdelta_mealy_pkg::*;
(
    input  logic   x_in,
    input  state_t st,
    output state_t mask
);

    // Product terms of the mask functions.
    logic t_hi_all;
    logic t_lo_xq1;
    logic t_lo_q1q0;

    // Form the individual products.
    always_comb begin
        t_hi_all  = x_in & st[1] & st[0];
        t_lo_xq1  = ~x_in & ~st[1];
        t_lo_q1q0 = ~st[1] & st[0];
    end

    // Combine the products into the mask bits.
    always_comb begin
        mask[1] = ~st[0] ^ t_hi_all;
        mask[0] = 1'b1 ^ t_lo_xq1 ^ t_lo_q1q0;
    end

endmodule

// File: rtl/xdelta_ctrl.sv
// Control decoder.
// Maps the update control and the clear control to a register action.
//   c=0,r=0: load
//   c=1,r=0: keep
//   c=1,r=1: clear
//   c=0,r=1: keep (a clear is only honoured with c=1)
// Assumes both controls are synchronous to the system clock.
module xdelta_ctrl
    import xdelta_mealy_pkg::*;
(
    input  logic      ctl_c,
    input  logic      ctl_r,
    output reg_mode_e mode
);

    // Decode the control pair into a register action.
    always_comb begin
        unique case ({ctl_c, ctl_r})
            2'b00:   mode = MODE_LOAD;
            2'b11:   mode = MODE_CLEAR;
            default: mode = MODE_KEEP;
        endcase
    end

endmodule

// File: rtl/xdelta_zout.sv
// Mealy output stage.
// Produces the output from the data input and the low state bit, with no
// register in the path. Assumes the state input comes straight from the
// state register.
module xdelta_zout (
    input  logic clk,
    input  logic rst_n,
    input  logic x_in,
    input  logic st_lo,
    output logic z_out
);

    // Output equation.
    always_comb begin
        z_out = st_lo ^ ~x_in;
    end

    // A change of x with the state bit steady must flip the output.
    AST_Z_TRACKS_X: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(x_in) && $stable(st_lo)) |-> !$stable(z_out)); // R6

endmodule

// File: rtl/xdelta_mealy.sv
// Top level: two-bit Mealy machine whose next state is the present state
// XOR an update mask.
// Holds the state register, selects keep / load / clear from the control
// decoder and drives the Mealy output. Assumes the controls and the data
// input are synchronous to clk. The synchronous active-low reset overrides
// every control combination.
module xdelta_mealy
    import xdelta_mealy_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ctl_c,
    input  logic               ctl_r,
    input  logic               x_in,
    output logic               z_out,
    output logic [STATE_W-1:0] state_q
);

    state_t    st_r;
    state_t    mask;
    state_t    st_next;
    reg_mode_e mode;

    xdelta_mask u_mask (
        .x_in (x_in),
        .st   (st_r),
        .mask (mask)
    );

    xdelta_ctrl u_ctrl (
        .ctl_c (ctl_c),
        .ctl_r (ctl_r),
        .mode  (mode)
    );

    xdelta_zout u_zout (
        .clk   (clk),
        .rst_n (rst_n),
        .x_in  (x_in),
        .st_lo (st_r[0]),
        .z_out (z_out)
    );

    // Select the value the register takes at the next edge.
    always_comb begin
        unique case (mode)
            MODE_LOAD:  st_next = st_r ^ mask;
            MODE_CLEAR: st_next = CLEAR_STATE;
            default:    st_next = st_r;
        endcase
    end

    // State register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) st_r <= CLEAR_STATE;
        else        st_r <= st_next;
    end

    // Expose the present state.
    always_comb begin
        state_q = st_r;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (state_q == '0)); // R1
    AST_LOAD_XOR_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_c && !ctl_r) |=> (state_q == ($past(state_q) ^ $past(mask)))); // R2
    AST_KEEP_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_c && !ctl_r) |=> $stable(state_q)); // R3
    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_c && ctl_r) |=> (state_q == '0)); // R4
    AST_LONE_CLEAR_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctl_c && ctl_r) |=> $stable(state_q)); // R5

endmodule

// File: tb/xdelta_mealy_tb_top.sv
module xdelta_mealy_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ctl_c = 1'b1;
    logic       ctl_r = 1'b0;
    logic       x_in = 1'b0;
    logic       z_out;
    logic [1:0] state_q;

    int total = 0;
    int bad = 0;
    logic [1:0] model_st = 2'b00;
    string last_tag = "R1";
    bit finished = 0;

    always #5 clk = ~clk;

    xdelta_mealy dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .ctl_c   (ctl_c),
        .ctl_r   (ctl_r),
        .x_in    (x_in),
        .z_out   (z_out),
        .state_q (state_q)
    );

    // Reference transition table for a load.
    function automatic logic [1:0] ref_next(logic [1:0] s, logic x);
        case ({x, s})
            3'b000: return 2'b10;
            3'b001: return 2'b00;
            3'b010: return 2'b01;
            3'b011: return 2'b10;
            3'b100: return 2'b11;
            3'b101: return 2'b01;
            3'b110: return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    // Reference output table.
    function automatic logic ref_z(logic [1:0] s, logic x);
        case ({x, s})
            3'b000, 3'b010, 3'b101, 3'b111: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check_state(string tag);
        total++;
        if (state_q !== model_st) begin
            bad++;
            $display("FAIL %s state actual=%b expected=%b", tag, state_q, model_st);
        end
    endtask

    task automatic check_z();
        total++;
        if (z_out !== ref_z(model_st, x_in)) begin
            bad++;
            $display("FAIL R6 z actual=%b expected=%b", z_out, ref_z(model_st, x_in));
        end
    endtask

    // One cycle: check the state left by the previous edge, drive, check z,
    // then apply the edge to the model.
    task automatic step(logic rn, logic c, logic r, logic x);
        @(negedge clk);
        check_state(last_tag);
        rst_n = rn; ctl_c = c; ctl_r = r; x_in = x;
        #1;
        check_z();
        @(posedge clk);
        if (!rn) begin
            model_st = 2'b00; last_tag = "R1";
        end else if (!c && !r) begin
            model_st = ref_next(model_st, x); last_tag = "R2";
        end else if (c && r) begin
            model_st = 2'b00; last_tag = "R4";
        end else if (c) begin
            last_tag = "R3";
        end else begin
            last_tag = "R5";
        end
    endtask

    initial begin
        void'($urandom(32'h1234_5678));
        // R1: reset, also on top of a load request.
        step(1'b0, 1'b0, 1'b0, 1'b1);
        step(1'b0, 1'b0, 1'b0, 1'b0);
        // R7: state visible after reset.
        @(negedge clk);
        total++;
        if (state_q !== 2'b00) begin
            bad++;
            $display("FAIL R7 state actual=%b expected=%b", state_q, 2'b00);
        end
        // R2: directed walk covering every state/input pair.
        step(1'b1, 1'b0, 1'b0, 1'b0); // 00 -> 10
        step(1'b1, 1'b0, 1'b0, 1'b0); // 10 -> 01
        step(1'b1, 1'b0, 1'b0, 1'b1); // 01 -> 01
        step(1'b1, 1'b0, 1'b0, 1'b0); // 01 -> 00
        step(1'b1, 1'b0, 1'b0, 1'b1); // 00 -> 11
        step(1'b1, 1'b0, 1'b0, 1'b0); // 11 -> 10
        step(1'b1, 1'b0, 1'b0, 1'b1); // 10 -> 01
        step(1'b1, 1'b1, 1'b1, 1'b0); // R4 clear -> 00
        step(1'b1, 1'b0, 1'b0, 1'b1); // 00 -> 11
        step(1'b1, 1'b0, 1'b0, 1'b1); // 11 -> 00
        step(1'b1, 1'b0, 1'b0, 1'b1); // 00 -> 11
        step(1'b1, 1'b1, 1'b0, 1'b0); // R3 keep 11
        step(1'b1, 1'b0, 1'b1, 1'b1); // R5 lone clear keeps 11
        step(1'b1, 1'b0, 1'b1, 1'b0); // R5 again, x toggled for R6
        step(1'b1, 1'b0, 1'b0, 1'b0); // 11 -> 10 seen after R5
        step(1'b1, 1'b0, 1'b0, 1'b1); // 10 -> 01
        step(1'b0, 1'b0, 1'b0, 1'b1); // R1 reset beats load
        // Constrained random mix.
        for (int i = 0; i < 400; i++) begin
            int unsigned pick = $urandom_range(0, 9);
            logic c, r, rn;
            rn = ($urandom_range(0, 39) != 0);
            c = (pick >= 5);
            r = (pick == 9) || (pick == 4);
            step(rn, c, r, 1'($urandom_range(0, 1)));
        end
        @(negedge clk);
        check_state(last_tag);
        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #2000000;
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule